// File: doc/BRIEF.md
# Non-Blocking Coprocessor Result Tracker

This block sits between one processor core and a shared, pipelined math coprocessor such as a CORDIC engine. It counts the commands the core has issued that have not yet produced a result. It keeps the most recent X/Y result pair in a single holding register and answers the core's X and Y read strobes. A read never locks the core up. If the requested half is ready, it is returned. If it is not ready and nothing is in flight, the read completes at once with a status bit set and the in-flight count in place of data. If work is still in flight, the core is stalled, but only for a bounded number of cycles.

There is no result queue. A result that arrives before the previous pair has been fully read overwrites it and raises a sticky overrun flag. A read that completes without data raises a sticky underrun flag. A counter of owed reads grows by two for each arriving pair and shrinks by one for each read that returns data, so recovery code can see how many reads are still expected. A clear strobe returns every counter and flag to its reset state, so software can resynchronise after an interrupt or after a lost command.

Top module: `cop_result_tracker`

## Requirements
- R1: `inflight` rises by one on each `cmd_issue` and falls by one on each `res_valid`, with a floor of zero and a ceiling of MAX_INFLIGHT. A cycle that has both strobes leaves it unchanged.
- R2: A read of a half that is ready returns that half with `rd_stat`=0. `rd_ack` is high in the cycle after the strobe, and `stall` is never raised.
- R3: A read of a half that is not ready, issued while `inflight` is zero, raises `rd_ack` in the next cycle with `rd_stat`=1 and `rd_data`=0, and never raises `stall`.
- R4: A read of a half that is not ready, issued while `inflight` is non-zero, holds `stall` high until the result arrives, then returns the half with `rd_stat`=0.
- R5: `stall` stays high for at most LAT+1 consecutive cycles. If the half is still missing after that, the read completes with `rd_stat`=1 and `rd_data` equal to the current `inflight` value.
- R6: `owed` rises by 2 on each arriving result and falls by 1 on each read that returns data. It saturates at 4 and does not go below 0.
- R7: Every read that completes with `rd_stat`=1 sets the sticky `underrun` flag.
- R8: There is a single holding register. A newer result replaces both halves, and later reads return the newer values.
- R9: A result that arrives while either half of the held pair is still unread sets the sticky `overrun` flag.
- R10: A pair is consumed only after both halves have been read, in either order. Reading X a second time is a read of a missing half and does not consume Y.
- R11: A `flag_clr` pulse zeroes `inflight` and `owed`, clears `underrun`, `overrun` and both unread halves, and ends a stalled read. That read completes in the next cycle with `rd_stat`=1 and `rd_data`=0. A read strobe in the same cycle as `flag_clr` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_issue | input | 1 | Core issued a command to the coprocessor |
| res_valid | input | 1 | Coprocessor delivers a result pair |
| res_x | input | W | X half of the arriving result |
| res_y | input | W | Y half of the arriving result |
| rd_x | input | 1 | Core requests the X half |
| rd_y | input | 1 | Core requests the Y half (X wins if both are high) |
| flag_clr | input | 1 | Resynchronise: clear counters and flags |
| rd_ack | output | 1 | Read completed this cycle |
| rd_data | output | W | Result half, or in-flight count when `rd_stat` is set |
| rd_stat | output | 1 | Read completed without data |
| stall | output | 1 | Core must hold while a read waits |
| inflight | output | CW | Commands issued but not yet returned |
| owed | output | 3 | Reads still expected by the returned results |
| underrun | output | 1 | Sticky: a read completed without data |
| overrun | output | 1 | Sticky: unread result was overwritten |

## Verification
The bound checker watches several properties on every cycle. It bounds the length of any stall run and checks the zero net change of `inflight` when a command and a result coincide. It checks that the owed-read ceiling holds and that a read returning data is never served while `owed` is zero. It also checks that the two error flags are set and stay sticky, and that the clear strobe leaves everything in its reset state. Some behaviours can be shown only by the bench's scenarios. These are the data values returned after an overwrite, reading Y before X, and a repeated X read that leaves Y intact. They also include a lost command that forces the timeout path, and a clear that arrives during a stalled read.

// File: rtl/ctrk_pkg.sv
package ctrk_pkg;

  localparam int unsigned OWED_CAP = 4;

  typedef enum logic {HALF_X = 1'b0, HALF_Y = 1'b1} half_e;

  // Up/down step with floor at zero and ceiling at cap; both strobes cancel.
  function automatic int unsigned step_count(int unsigned cur, logic up, logic dn,
                                             int unsigned cap);
    if (up && !dn) return (cur >= cap) ? cap : cur + 1;
    if (dn && !up) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  // Owed-read bookkeeping: +2 per arriving pair, -1 per data read, clamp 0..OWED_CAP.
  function automatic logic [2:0] owed_step(logic [2:0] cur, logic add_pair, logic take_one);
    int v;
    v = int'(cur) + (add_pair ? 2 : 0) - (take_one ? 1 : 0);
    if (v > int'(OWED_CAP)) v = int'(OWED_CAP);
    if (v < 0) v = 0;
    return 3'(v);
  endfunction

endpackage

// File: rtl/ctrk_flight_ctr.sv
module ctrk_flight_ctr
  import ctrk_pkg::*;
#(
  parameter int unsigned MAX_INFLIGHT = 15,
  localparam int unsigned CW = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= CW'(step_count(int'(cnt), inc, dec, MAX_INFLIGHT));
  end

endmodule

// File: rtl/ctrk_pair_hold.sv
module ctrk_pair_hold
  import ctrk_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         arr,
  input  logic [W-1:0] ax,
  input  logic [W-1:0] ay,
  input  logic         take_x,
  input  logic         take_y,
  output logic [W-1:0] hx,
  output logic [W-1:0] hy,
  output logic         x_rdy,
  output logic         y_rdy,
  output logic [2:0]   owed,
  output logic         ovr_evt,
  output logic         overrun
);

  logic x_left, y_left;

  // Halves that stay unread after this cycle's read, before any new arrival.
  assign x_left  = x_rdy & ~take_x;
  assign y_left  = y_rdy & ~take_y;
  assign ovr_evt = arr & (x_left | y_left);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hx <= '0; hy <= '0;
      x_rdy <= 1'b0; y_rdy <= 1'b0;
      owed <= '0; overrun <= 1'b0;
    end else if (clr) begin
      x_rdy <= 1'b0; y_rdy <= 1'b0;
      owed <= '0; overrun <= 1'b0;
    end else begin
      if (arr) begin
        hx <= ax;
        hy <= ay;
      end
      x_rdy   <= arr | x_left;
      y_rdy   <= arr | y_left;
      owed    <= owed_step(owed, arr, take_x | take_y);
      overrun <= overrun | ovr_evt;
    end
  end

endmodule

// File: rtl/ctrk_read_ctl.sv
module ctrk_read_ctl
  import ctrk_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned CW  = 4,
  parameter int unsigned LAT = 8,
  localparam int unsigned WCW = $clog2(LAT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rd_x,
  input  logic          rd_y,
  input  logic          x_rdy,
  input  logic          y_rdy,
  input  logic [W-1:0]  hx,
  input  logic [W-1:0]  hy,
  input  logic [CW-1:0] inflight,
  output logic          take_x,
  output logic          take_y,
  output logic          skip_evt,
  output logic          stall,
  output logic          rd_ack,
  output logic [W-1:0]  rd_data,
  output logic          rd_stat,
  output logic          underrun
);

  logic           pend;
  half_e          pend_sel;
  logic [WCW-1:0] wcnt;

  logic  req_new, active, have, serve, hold, timed_out;
  half_e sel;

  assign req_new   = ~pend & (rd_x | rd_y);
  assign sel       = pend ? pend_sel : (rd_x ? HALF_X : HALF_Y);
  assign active    = pend | req_new;
  assign have      = (sel == HALF_X) ? x_rdy : y_rdy;
  assign timed_out = pend & (wcnt == WCW'(LAT));
  assign serve     = active & have & ~clr;
  assign skip_evt  = active & ~have & ~clr & ((inflight == '0) | timed_out);
  assign hold      = active & ~have & ~clr & ~skip_evt;
  assign take_x    = serve & (sel == HALF_X);
  assign take_y    = serve & (sel == HALF_Y);
  assign stall     = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_sel <= HALF_X; wcnt <= '0;
      rd_ack <= 1'b0; rd_stat <= 1'b0; rd_data <= '0; underrun <= 1'b0;
    end else if (clr) begin
      rd_ack   <= pend;
      rd_stat  <= 1'b1;
      rd_data  <= '0;
      pend     <= 1'b0;
      wcnt     <= '0;
      underrun <= 1'b0;
    end else begin
      rd_ack   <= serve | skip_evt;
      rd_stat  <= skip_evt;
      rd_data  <= serve ? ((sel == HALF_X) ? hx : hy) : W'(inflight);
      pend     <= hold;
      if (hold && !pend) pend_sel <= sel;
      wcnt     <= (hold && pend) ? wcnt + 1'b1 : '0;
      underrun <= underrun | skip_evt;
    end
  end

endmodule

// File: rtl/cop_result_tracker.sv
module cop_result_tracker
  import ctrk_pkg::*;
#(
  parameter int unsigned W            = 32,
  parameter int unsigned LAT          = 8,
  parameter int unsigned MAX_INFLIGHT = 15,
  localparam int unsigned CW = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_issue,
  input  logic          res_valid,
  input  logic [W-1:0]  res_x,
  input  logic [W-1:0]  res_y,
  input  logic          rd_x,
  input  logic          rd_y,
  input  logic          flag_clr,
  output logic          rd_ack,
  output logic [W-1:0]  rd_data,
  output logic          rd_stat,
  output logic          stall,
  output logic [CW-1:0] inflight,
  output logic [2:0]    owed,
  output logic          underrun,
  output logic          overrun
);

  logic         take_x, take_y, x_rdy, y_rdy;
  logic         ovr_evt, skip_evt;
  logic [W-1:0] hx, hy;

  ctrk_flight_ctr #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_flight (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr),
    .inc(cmd_issue), .dec(res_valid), .cnt(inflight)
  );

  ctrk_pair_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr),
    .arr(res_valid), .ax(res_x), .ay(res_y),
    .take_x(take_x), .take_y(take_y),
    .hx(hx), .hy(hy), .x_rdy(x_rdy), .y_rdy(y_rdy),
    .owed(owed), .ovr_evt(ovr_evt), .overrun(overrun)
  );

  ctrk_read_ctl #(.W(W), .CW(CW), .LAT(LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr),
    .rd_x(rd_x), .rd_y(rd_y), .x_rdy(x_rdy), .y_rdy(y_rdy),
    .hx(hx), .hy(hy), .inflight(inflight),
    .take_x(take_x), .take_y(take_y), .skip_evt(skip_evt),
    .stall(stall), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_stat(rd_stat), .underrun(underrun)
  );

endmodule

// File: rtl/cop_result_tracker_chk.sv
module cop_result_tracker_chk #(
  parameter int unsigned LAT = 8,
  parameter int unsigned CW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_issue,
  input logic          res_valid,
  input logic          rd_x,
  input logic          rd_y,
  input logic          flag_clr,
  input logic          rd_ack,
  input logic          rd_stat,
  input logic          stall,
  input logic [CW-1:0] inflight,
  input logic [2:0]    owed,
  input logic          underrun,
  input logic          overrun,
  input logic          ovr_evt,
  input logic          skip_evt
);

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)     run_len <= 0;
    else if (stall) run_len <= run_len + 1;
    else            run_len <= 0;
  end

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= LAT + 1); // R5

  AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue && res_valid && !flag_clr |=> inflight == $past(inflight)); // R1

  AST_EMPTY_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_x || rd_y) && !stall && inflight == '0 && !flag_clr |=> rd_ack && !stall); // R3

  AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= 3'd4); // R6

  AST_DATA_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !rd_stat |-> $past(owed) != 3'd0); // R6

  AST_SKIP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt && !flag_clr |=> underrun && rd_ack && rd_stat); // R7

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt && !flag_clr |=> overrun); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !flag_clr |=> overrun); // R9

  AST_CLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> inflight == '0 && owed == 3'd0 && !underrun && !overrun && !stall); // R11

endmodule

bind cop_result_tracker cop_result_tracker_chk #(.LAT(LAT), .CW(CW)) u_chk (.*);

// File: tb/cop_result_tracker_tb.sv
module cop_result_tracker_tb;

  localparam int unsigned W   = 32;
  localparam int unsigned LAT = 8;
  localparam int unsigned MXF = 15;
  localparam int unsigned CW  = $clog2(MXF + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_issue = 1'b0, rd_x = 1'b0, rd_y = 1'b0, flag_clr = 1'b0;
  logic          res_valid;
  logic [W-1:0]  res_x, res_y, rd_data;
  logic          rd_ack, rd_stat, stall, underrun, overrun;
  logic [CW-1:0] inflight;
  logic [2:0]    owed;

  int n_chk = 0, n_fail = 0, n_acks = 0, stall_cyc = 0;
  logic [W:0] exp_q[$];
  string      tag_q[$];

  // 125 MHz clock
  always #4ns clk = ~clk;

  cop_result_tracker #(.W(W), .LAT(LAT), .MAX_INFLIGHT(MXF)) u_dut (.*);

  // Fixed-latency coprocessor stand-in; stub_en = 0 models a lost command.
  logic          stub_en = 1'b1;
  logic [LAT-1:0] v_sh = '0;
  logic [15:0]   id_sh [LAT];
  logic [15:0]   nid = 16'd0;

  always @(posedge clk) begin
    v_sh <= {v_sh[LAT-2:0], cmd_issue & stub_en};
    for (int i = LAT - 1; i > 0; i--) id_sh[i] <= id_sh[i-1];
    id_sh[0] <= nid;
    if (cmd_issue && stub_en) nid <= nid + 16'd1;
  end
  assign res_valid = v_sh[LAT-1];
  assign res_x = 32'h1000_0000 + 32'(id_sh[LAT-1]);
  assign res_y = 32'h2000_0000 + 32'(id_sh[LAT-1]);

  function automatic logic [W-1:0] xv(int id); return 32'h1000_0000 + 32'(id); endfunction
  function automatic logic [W-1:0] yv(int id); return 32'h2000_0000 + 32'(id); endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every completed read.
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall) stall_cyc++;
      if (rd_ack) begin
        n_acks++;
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected rd_ack", 1, 0);
        end else begin
          logic [W:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rd_stat, rd_data} == e, t, {rd_stat, rd_data}, e);
        end
      end
    end
  end

  task automatic issue();
    @(negedge clk) cmd_issue = 1'b1;
    @(negedge clk) cmd_issue = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  // Driver: pushes the expected reply, pulses the strobe, waits for the reply.
  task automatic rd(bit y, bit st, logic [W-1:0] d, string tag, int exp_stall);
    int a0, s0, g;
    exp_q.push_back({st, d});
    tag_q.push_back(tag);
    @(negedge clk);
    a0 = n_acks; s0 = stall_cyc;
    if (y) rd_y = 1'b1; else rd_x = 1'b1;
    @(negedge clk) begin rd_x = 1'b0; rd_y = 1'b0; end
    g = 0;
    do begin @(posedge clk); g++; end while (n_acks == a0 && g < 60);
    check(n_acks == a0 + 1, {tag, " reply count"}, n_acks - a0, 1);
    if (exp_stall >= 0)
      check(stall_cyc - s0 == exp_stall, {tag, " stall cycles"}, stall_cyc - s0, exp_stall);
    @(negedge clk);
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(inflight == 0 && owed == 0, "R1 R6 reset counters", {inflight, owed}, 0);
    check(!stall && !underrun && !overrun && !rd_ack, "R11 reset flags",
          {stall, underrun, overrun, rd_ack}, 0);

    // R4 / R2: issue then read at once (wait), then the other half (ready)
    issue();
    check(inflight == 1, "R1 count after issue", inflight, 1);
    rd(0, 0, xv(0), "R4 wait for X", -1);
    check(stall_cyc > 0, "R4 stall observed", stall_cyc, 1);
    rd(1, 0, yv(0), "R2 ready Y", 0);
    check(inflight == 0 && owed == 0, "R1 R6 drained", {inflight, owed}, 0);

    // R10: Y before X consumes the pair
    issue(); repeat (12) @(negedge clk);
    check(owed == 2, "R6 owed after arrival", owed, 2);
    rd(1, 0, yv(1), "R10 Y first", 0);
    rd(0, 0, xv(1), "R10 then X", 0);
    issue(); repeat (12) @(negedge clk);
    check(!overrun, "R10 pair consumed, no overrun", overrun, 0);
    rd(0, 0, xv(2), "R2 X2", 0);
    rd(1, 0, yv(2), "R2 Y2", 0);

    // R3 / R7: read with nothing pending
    rd(0, 1, 0, "R3 empty read", 0);
    check(underrun, "R7 underrun set", underrun, 1);
    clr();
    check(!underrun, "R11 underrun cleared", underrun, 0);

    // R10: repeated X does not consume Y
    issue(); repeat (12) @(negedge clk);
    rd(0, 0, xv(3), "R10 X3", 0);
    rd(0, 1, 0, "R10 second X skipped", 0);
    rd(1, 0, yv(3), "R10 Y3 still held", 0);
    clr();

    // R8 / R9 / R6: overwrite and saturation
    issue(); issue(); repeat (14) @(negedge clk);
    check(overrun, "R9 overrun on overwrite", overrun, 1);
    check(owed == 4, "R6 owed 2+2", owed, 4);
    issue(); repeat (12) @(negedge clk);
    check(owed == 4, "R6 owed saturates", owed, 4);
    rd(0, 0, xv(6), "R8 newest X", 0);
    rd(1, 0, yv(6), "R8 newest Y", 0);
    check(owed == 2 && overrun, "R6 R9 after reads", {owed, overrun}, 5'h5);
    clr();
    check(owed == 0 && !overrun, "R11 clear owed/overrun", {owed, overrun}, 0);

    // R1: command and result in the same cycle
    issue();
    do @(negedge clk); while (!res_valid);
    cmd_issue = 1'b1;
    @(negedge clk) cmd_issue = 1'b0;
    check(inflight == 1, "R1 net zero", inflight, 1);
    repeat (12) @(negedge clk);
    rd(0, 0, xv(8), "R8 X8", 0);
    rd(1, 0, yv(8), "R8 Y8", 0);
    clr();

    // R5: lost command, bounded stall, count returned
    stub_en = 1'b0;
    issue();
    rd(0, 1, 1, "R5 timeout returns count", LAT + 1);
    check(underrun && inflight == 1, "R5 R7 after timeout", {underrun, inflight}, 17);
    clr();
    check(inflight == 0 && !underrun, "R11 recover", {underrun, inflight}, 0);

    // R11: clear during a stalled read
    issue();
    begin
      int a0;
      exp_q.push_back({1'b1, 32'h0});
      tag_q.push_back("R11 abort stalled read");
      @(negedge clk);
      a0 = n_acks;
      rd_x = 1'b1;
      @(negedge clk) rd_x = 1'b0;
      repeat (2) @(negedge clk);
      check(stall, "R4 stalled before clear", stall, 1);
      flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
      @(negedge clk);
      check(n_acks == a0 + 1, "R11 abort reply", n_acks - a0, 1);
      check(!stall && !underrun && inflight == 0, "R11 state after abort",
            {stall, underrun, inflight}, 0);
    end
    stub_en = 1'b1;

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule